// File: doc/BRIEF.md
# Tagged Geometric-History Branch Direction Predictor

This block predicts the direction of conditional branches. A PC-indexed table of 2-bit counters gives a fallback guess. Four partially tagged tables refine that guess. Each one is indexed and tagged by hashing the branch PC with a folded copy of the global outcome history and a short path history. The history length doubles from one tagged table to the next (5, 10, 20 and 40 outcomes by default). The lookup is combinational on `pred_pc_i`. It returns the direction, the identity of the providing table, and an opaque lookup record that the caller keeps until the branch resolves.

On resolution the caller presents the PC, the real outcome, a 2-bit random value and the saved record on the update port. The block trains the provider and adjusts its useful counter. On a misprediction it either claims a free entry in a table with longer history or ages the eligible entries. It also shifts the outcome into the global history and PC bit 0 into the path history. History moves only on updates, so the block handles one branch in flight at a time.

Top module: `tage_pred`

## Requirements
- R1: After reset every tagged entry is invalid, every base counter holds 1 (weakly not taken), and both histories are zero, so every PC predicts not taken with provider 0.
- R2: The base counter is selected by `pc[5:0]` and predicts taken when its bit 1 is set. It is a 2-bit saturating counter (0..3), and an update moves it toward the outcome only when the saved provider is 0.
- R3: Tagged table t (0..3) uses history length 5·2^t. With h[i] the outcome i updates ago, fold_W is the W-bit value whose bit j is the XOR of h[i] over i < length with i mod W = j. The index is pc[4:0] ^ fold_5 ^ path, and the tag is pc[12:5] ^ fold_8.
- R4: A tagged table hits when its entry is valid and its tag matches. The provider is the hitting table with the longest history, reported as t+1, and it predicts taken when its signed 3-bit counter is ≥ 0. With no hit the provider is 0 and the base counter decides.
- R5: The alternate prediction is that of the next-longest hitting table, or the base counter if no other table hits.
- R6: On update, a tagged provider's counter moves one step toward the outcome, saturating at +3 and −4.
- R7: When the prediction and the alternate differ, the provider's useful counter (0..3) rises by one if the prediction was right and falls by one if it was wrong, saturating at both ends.
- R8: On a misprediction, the eligible tables are those with longer history than the provider. Let F be the eligible tables whose entry at the saved index has useful 0, in ascending history order. The table F[r] is chosen when the random value r is below |F|, otherwise F[0]. The chosen entry becomes valid with the saved tag, counter 0 if the outcome was taken or −1 if not, and useful 0. At most one table allocates per update.
- R9: On a misprediction with F empty, the useful counter of every eligible entry at its saved index drops by one.
- R10: Every update shifts the outcome into global history bit 0 and `upd_pc_i[0]` into path history bit 0.
- R11: A correct prediction, or a provider that is the longest table, allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_pc_i | input | 16 | PC of the branch to predict |
| pred_taken_o | output | 1 | Predicted direction |
| pred_provider_o | output | 3 | 0 = base table, t+1 = tagged table t |
| pred_info_o | output | 57 | Lookup record to be returned with the update |
| upd_valid_i | input | 1 | Update strobe |
| upd_pc_i | input | 16 | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome |
| upd_rand_i | input | 2 | Random selector for allocation |
| upd_info_i | input | 57 | Record saved from the lookup |

## Verification
The hardest case to reach is a misprediction whose eligible entries all carry nonzero useful counters, because those counters rise only when provider and alternate disagree and the provider is right. The bench drives a long pseudo-random stream over a small pool of PCs with outcomes tied to recent history. This keeps many tagged entries both hitting and useful, so allocations collide with occupied slots. A bench model computes the folds from the raw history and follows every table entry, so any divergence in allocation, aging or hashing shows up in later predictions.

// File: rtl/tage_pkg.sv
package tage_pkg;
  function automatic logic signed [2:0] ctr3_step(input logic signed [2:0] c, input logic up);
    if (up) return (c == 3'sd3) ? c : c + 3'sd1;
    return (c == 3'sb100) ? c : c - 3'sd1;
  endfunction

  function automatic logic [1:0] ctr2_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/tage_fold.sv
module tage_fold #(
  parameter int HIST_LEN = 5,
  parameter int FOLD_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              in_bit_i,
  input  logic              out_bit_i,
  output logic [FOLD_W-1:0] fold_o
);
  localparam int OUT_POS = HIST_LEN % FOLD_W;

  logic [FOLD_W-1:0] fold_q, fold_d;

  // rotate, add the new bit at 0, cancel the bit that just aged past HIST_LEN
  always_comb begin
    fold_d = {fold_q[FOLD_W-2:0], fold_q[FOLD_W-1]};
    fold_d[0] = fold_d[0] ^ in_bit_i;
    fold_d[OUT_POS] = fold_d[OUT_POS] ^ out_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fold_q <= '0;
    else if (shift_i) fold_q <= fold_d;
  end

  assign fold_o = fold_q;

  AST_FOLD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(fold_q)); // R3
endmodule

// File: rtl/tage_base.sv
module tage_base #(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [1:0]       rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  import tage_pkg::*;
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] ctr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= 2'd1;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= ctr2_step(ctr_q[wr_idx_i], wr_taken_i);
    end
  end

  assign rd_ctr_o = ctr_q[rd_idx_i];

  AST_BASE_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_taken_i && ctr_q[wr_idx_i] == 2'd3) |=> ctr_q[$past(wr_idx_i)] == 2'd3); // R2
  AST_BASE_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_taken_i && ctr_q[wr_idx_i] == 2'd0) |=> ctr_q[$past(wr_idx_i)] == 2'd0); // R2
endmodule

// File: rtl/tage_tab.sv
module tage_tab #(
  parameter int IDX_W = 5,
  parameter int TAG_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [IDX_W-1:0]        rd_idx_i,
  input  logic [TAG_W-1:0]        rd_tag_i,
  output logic                    rd_hit_o,
  output logic signed [2:0]       rd_ctr_o,
  input  logic [IDX_W-1:0]        upd_idx_i,
  output logic [1:0]              upd_use_o,
  input  logic                    trn_en_i,
  input  logic                    trn_taken_i,
  input  logic                    use_inc_i,
  input  logic                    use_dec_i,
  input  logic                    age_en_i,
  input  logic                    alloc_en_i,
  input  logic [TAG_W-1:0]        alloc_tag_i,
  input  logic                    alloc_taken_i
);
  import tage_pkg::*;
  localparam int DEPTH = 1 << IDX_W;

  logic              vld_q [DEPTH];
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic signed [2:0] ctr_q [DEPTH];
  logic [1:0]        use_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        ctr_q[i] <= '0;
        use_q[i] <= '0;
      end
    end else if (alloc_en_i) begin
      vld_q[upd_idx_i] <= 1'b1;
      tag_q[upd_idx_i] <= alloc_tag_i;
      ctr_q[upd_idx_i] <= alloc_taken_i ? 3'sd0 : 3'sb111;
      use_q[upd_idx_i] <= 2'd0;
    end else begin
      if (trn_en_i) ctr_q[upd_idx_i] <= ctr3_step(ctr_q[upd_idx_i], trn_taken_i);
      if (use_inc_i && use_q[upd_idx_i] != 2'd3)
        use_q[upd_idx_i] <= use_q[upd_idx_i] + 2'd1;
      else if ((use_dec_i || age_en_i) && use_q[upd_idx_i] != 2'd0)
        use_q[upd_idx_i] <= use_q[upd_idx_i] - 2'd1;
    end
  end

  assign rd_hit_o  = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign rd_ctr_o  = ctr_q[rd_idx_i];
  assign upd_use_o = use_q[upd_idx_i];

  AST_CTR_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trn_en_i && !alloc_en_i && trn_taken_i && ctr_q[upd_idx_i] == 3'sd3)
    |=> ctr_q[$past(upd_idx_i)] == 3'sd3); // R6
  AST_CTR_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trn_en_i && !alloc_en_i && !trn_taken_i && ctr_q[upd_idx_i] == 3'sb100)
    |=> ctr_q[$past(upd_idx_i)] == 3'sb100); // R6
  AST_ALLOC_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i |-> use_q[upd_idx_i] == 2'd0); // R8
  AST_NO_TRAIN_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_en_i && trn_en_i)); // R8
endmodule

// File: rtl/tage_pred.sv
module tage_pred #(
  parameter int PC_W       = 16,
  parameter int N_TAB      = 4,
  parameter int BASE_IDX_W = 6,
  parameter int IDX_W      = 5,
  parameter int TAG_W      = 8,
  parameter int MIN_HIST   = 5,
  parameter int PATH_W     = 4,
  localparam int PROV_W    = $clog2(N_TAB + 1),
  localparam int INFO_W    = 2 + PROV_W + N_TAB * (IDX_W + TAG_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   pred_pc_i,
  output logic              pred_taken_o,
  output logic [PROV_W-1:0] pred_provider_o,
  output logic [INFO_W-1:0] pred_info_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [1:0]        upd_rand_i,
  input  logic [INFO_W-1:0] upd_info_i
);
  localparam int MAX_HIST = MIN_HIST << (N_TAB - 1);
  localparam int IDX_LO   = N_TAB * TAG_W;
  localparam int PROV_LO  = N_TAB * (IDX_W + TAG_W);
  localparam int ALT_BIT  = PROV_LO + PROV_W;
  localparam int PRED_BIT = ALT_BIT + 1;

  logic [MAX_HIST-1:0] ghist_q;
  logic [PATH_W-1:0]   path_q;

  logic [IDX_W-1:0]  rd_idx [N_TAB];
  logic [TAG_W-1:0]  rd_tag [N_TAB];
  logic signed [2:0] rd_ctr [N_TAB];
  logic [N_TAB-1:0]  hit;
  logic [1:0]        base_ctr;

  logic [IDX_W-1:0]  u_idx [N_TAB];
  logic [TAG_W-1:0]  u_tag [N_TAB];
  logic [1:0]        u_use [N_TAB];
  logic [PROV_W-1:0] u_prov;
  logic              u_pred, u_alt, mispred;
  logic [N_TAB-1:0]  trn_en, use_inc, use_dec, elig, free, alloc, age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ghist_q <= '0;
      path_q  <= '0;
    end else if (upd_valid_i) begin
      ghist_q <= {ghist_q[MAX_HIST-2:0], upd_taken_i};
      path_q  <= {path_q[PATH_W-2:0], upd_pc_i[0]};
    end
  end

  tage_base #(.IDX_W(BASE_IDX_W)) u_base (
    .clk_i, .rst_ni,
    .rd_idx_i   (pred_pc_i[BASE_IDX_W-1:0]),
    .rd_ctr_o   (base_ctr),
    .wr_en_i    (upd_valid_i && u_prov == '0),
    .wr_idx_i   (upd_pc_i[BASE_IDX_W-1:0]),
    .wr_taken_i (upd_taken_i)
  );

  assign u_prov  = upd_info_i[PROV_LO +: PROV_W];
  assign u_alt   = upd_info_i[ALT_BIT];
  assign u_pred  = upd_info_i[PRED_BIT];
  assign mispred = upd_valid_i && (u_pred != upd_taken_i);

  for (genvar t = 0; t < N_TAB; t++) begin : g_tab
    localparam int HL = MIN_HIST << t;
    logic [IDX_W-1:0] fold_idx;
    logic [TAG_W-1:0] fold_tag;

    tage_fold #(.HIST_LEN(HL), .FOLD_W(IDX_W)) u_fold_idx (
      .clk_i, .rst_ni,
      .shift_i (upd_valid_i), .in_bit_i (upd_taken_i),
      .out_bit_i (ghist_q[HL-1]), .fold_o (fold_idx)
    );
    tage_fold #(.HIST_LEN(HL), .FOLD_W(TAG_W)) u_fold_tag (
      .clk_i, .rst_ni,
      .shift_i (upd_valid_i), .in_bit_i (upd_taken_i),
      .out_bit_i (ghist_q[HL-1]), .fold_o (fold_tag)
    );

    assign rd_idx[t] = pred_pc_i[IDX_W-1:0] ^ fold_idx ^ IDX_W'(path_q);
    assign rd_tag[t] = pred_pc_i[IDX_W +: TAG_W] ^ fold_tag;
    assign u_idx[t]  = upd_info_i[IDX_LO + t*IDX_W +: IDX_W];
    assign u_tag[t]  = upd_info_i[t*TAG_W +: TAG_W];

    assign trn_en[t]  = upd_valid_i && (int'(u_prov) == t + 1);
    assign use_inc[t] = trn_en[t] && (u_pred != u_alt) && (u_pred == upd_taken_i);
    assign use_dec[t] = trn_en[t] && (u_pred != u_alt) && (u_pred != upd_taken_i);
    assign elig[t]    = mispred && (int'(u_prov) <= t);
    assign free[t]    = elig[t] && (u_use[t] == 2'd0);
    assign age[t]     = elig[t] && (free == '0);

    tage_tab #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tab (
      .clk_i, .rst_ni,
      .rd_idx_i      (rd_idx[t]),
      .rd_tag_i      (rd_tag[t]),
      .rd_hit_o      (hit[t]),
      .rd_ctr_o      (rd_ctr[t]),
      .upd_idx_i     (u_idx[t]),
      .upd_use_o     (u_use[t]),
      .trn_en_i      (trn_en[t]),
      .trn_taken_i   (upd_taken_i),
      .use_inc_i     (use_inc[t]),
      .use_dec_i     (use_dec[t]),
      .age_en_i      (age[t]),
      .alloc_en_i    (alloc[t]),
      .alloc_tag_i   (u_tag[t]),
      .alloc_taken_i (upd_taken_i)
    );
  end

  // pick the r-th free eligible table, or the first if r is out of range
  int nfree, sel, cnt;
  always_comb begin
    alloc = '0;
    cnt   = 0;
    nfree = $countones(free);
    sel   = (int'(upd_rand_i) < nfree) ? int'(upd_rand_i) : 0;
    for (int t = 0; t < N_TAB; t++) begin
      if (free[t]) begin
        if (cnt == sel) alloc[t] = 1'b1;
        cnt = cnt + 1;
      end
    end
  end

  logic [PROV_W-1:0] prov;
  logic              prov_dir, alt_dir, found, found2;
  always_comb begin
    prov     = '0;
    prov_dir = base_ctr[1];
    alt_dir  = base_ctr[1];
    found    = 1'b0;
    found2   = 1'b0;
    for (int t = N_TAB - 1; t >= 0; t--) begin
      if (hit[t]) begin
        if (!found) begin
          prov     = PROV_W'(t + 1);
          prov_dir = !rd_ctr[t][2];
          found    = 1'b1;
        end else if (!found2) begin
          alt_dir = !rd_ctr[t][2];
          found2  = 1'b1;
        end
      end
    end
  end

  always_comb begin
    pred_info_o = '0;
    pred_info_o[PRED_BIT] = prov_dir;
    pred_info_o[ALT_BIT]  = alt_dir;
    pred_info_o[PROV_LO +: PROV_W] = prov;
    for (int t = 0; t < N_TAB; t++) begin
      pred_info_o[IDX_LO + t*IDX_W +: IDX_W] = rd_idx[t];
      pred_info_o[t*TAG_W +: TAG_W]          = rd_tag[t];
    end
  end

  assign pred_taken_o    = prov_dir;
  assign pred_provider_o = prov;

  AST_ALLOC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(alloc)); // R8
  AST_NO_ALLOC_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && u_pred == upd_taken_i) |-> alloc == '0); // R11
  AST_NO_ALLOC_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(u_prov) == N_TAB) |-> alloc == '0); // R11
  AST_HIST_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> ghist_q[0] == $past(upd_taken_i)); // R10
  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghist_q) && $stable(path_q)); // R10
  AST_PROV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pred_provider_o) <= N_TAB); // R4
endmodule

// File: tb/tb_tage_pred.sv
module tb_tage_pred;
  localparam int NT = 4, BW = 6, IW = 5, TW = 8, L0 = 5, PW = 4;
  localparam int MAXH = L0 << (NT - 1);
  localparam int INFO_W = 2 + 3 + NT * (IW + TW);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [15:0] pred_pc_i = '0;
  logic pred_taken_o;
  logic [2:0] pred_provider_o;
  logic [INFO_W-1:0] pred_info_o;
  logic upd_valid_i = 1'b0;
  logic [15:0] upd_pc_i = '0;
  logic upd_taken_i = 1'b0;
  logic [1:0] upd_rand_i = '0;
  logic [INFO_W-1:0] upd_info_i = '0;

  always #2 clk_i = ~clk_i;

  tage_pred dut (.*);

  int n_chk = 0, n_fail = 0;

  // bench model
  bit m_vld [NT][1<<IW];
  int m_tag [NT][1<<IW];
  int m_ctr [NT][1<<IW];
  int m_use [NT][1<<IW];
  int m_base [1<<BW];
  logic [MAXH-1:0] m_gh;
  int m_path;

  function automatic int fold_of(int len, int w);
    int r = 0;
    for (int i = 0; i < len; i++) if (m_gh[i]) r ^= (1 << (i % w));
    return r;
  endfunction

  task automatic check(input string req, input bit ok, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < (1 << IW); i++) begin
        m_vld[t][i] = 0; m_tag[t][i] = 0; m_ctr[t][i] = 0; m_use[t][i] = 0;
      end
    for (int i = 0; i < (1 << BW); i++) m_base[i] = 1;
    m_gh = '0;
    m_path = 0;
  endtask

  int e_ix [NT];
  int e_tg [NT];
  int e_prov, e_dir, e_alt;

  task automatic model_lookup(input int pc);
    bit found, found2;
    e_prov = 0;
    e_dir = (m_base[pc % (1 << BW)] >> 1) & 1;
    e_alt = e_dir;
    found = 0; found2 = 0;
    for (int t = 0; t < NT; t++) begin
      e_ix[t] = ((pc & ((1 << IW) - 1)) ^ fold_of(L0 << t, IW) ^ m_path) & ((1 << IW) - 1);
      e_tg[t] = ((pc >> IW) & ((1 << TW) - 1)) ^ fold_of(L0 << t, TW);
    end
    for (int t = NT - 1; t >= 0; t--) begin
      if (m_vld[t][e_ix[t]] && m_tag[t][e_ix[t]] == e_tg[t]) begin
        if (!found) begin
          e_prov = t + 1; e_dir = (m_ctr[t][e_ix[t]] >= 0); found = 1;
        end else if (!found2) begin
          e_alt = (m_ctr[t][e_ix[t]] >= 0); found2 = 1;
        end
      end
    end
  endtask

  task automatic peek(input logic [15:0] pc, input string req);
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    pred_pc_i = pc;
    #1;
    model_lookup(int'(pc));
    check(req, pred_taken_o == e_dir[0] && int'(pred_provider_o) == e_prov,
          {pred_provider_o, pred_taken_o}, (e_prov << 1) | e_dir);
  endtask

  task automatic step(input logic [15:0] pc, input bit tk, input logic [1:0] rnd, input string req);
    int p, fl [NT], nf, s, bi;
    peek(pc, req);
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = tk; upd_rand_i = rnd;
    upd_info_i = pred_info_o;
    @(posedge clk_i);
    #1 upd_valid_i = 1'b0;
    p = e_prov;
    bi = int'(pc) % (1 << BW);
    if (p == 0) begin
      if (tk && m_base[bi] < 3) m_base[bi]++;
      if (!tk && m_base[bi] > 0) m_base[bi]--;
    end else begin
      if (tk && m_ctr[p-1][e_ix[p-1]] < 3) m_ctr[p-1][e_ix[p-1]]++;
      if (!tk && m_ctr[p-1][e_ix[p-1]] > -4) m_ctr[p-1][e_ix[p-1]]--;
      if (e_dir != e_alt) begin
        if (e_dir == int'(tk) && m_use[p-1][e_ix[p-1]] < 3) m_use[p-1][e_ix[p-1]]++;
        if (e_dir != int'(tk) && m_use[p-1][e_ix[p-1]] > 0) m_use[p-1][e_ix[p-1]]--;
      end
    end
    if (e_dir != int'(tk)) begin
      nf = 0;
      for (int t = p; t < NT; t++) if (m_use[t][e_ix[t]] == 0) begin fl[nf] = t; nf++; end
      if (nf > 0) begin
        s = (int'(rnd) < nf) ? int'(rnd) : 0;
        m_vld[fl[s]][e_ix[fl[s]]] = 1;
        m_tag[fl[s]][e_ix[fl[s]]] = e_tg[fl[s]];
        m_ctr[fl[s]][e_ix[fl[s]]] = tk ? 0 : -1;
        m_use[fl[s]][e_ix[fl[s]]] = 0;
      end else begin
        for (int t = p; t < NT; t++) if (m_use[t][e_ix[t]] > 0) m_use[t][e_ix[t]]--;
      end
    end
    m_gh = {m_gh[MAXH-2:0], tk};
    m_path = ((m_path << 1) | int'(pc[0])) & ((1 << PW) - 1);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got=hang exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state, base only, not taken
    for (int pc = 0; pc < 64; pc++) begin
      peek(16'(pc * 1031), "R1");
      check("R1", pred_provider_o == 3'd0 && !pred_taken_o, {pred_provider_o, pred_taken_o}, 0);
    end
    // R2: base training and saturation
    for (int k = 0; k < 4; k++)
      for (int pc = 0; pc < 16; pc++) step(16'(pc), k != 3, 2'(k), "R2");
    // R6: one branch always taken
    for (int k = 0; k < 40; k++) step(16'h1234, 1'b1, 2'(k), "R6 R4");
    for (int k = 0; k < 12; k++) step(16'h1234, 1'b0, 2'(k), "R6");
    // R3 R10: loop pattern exercises the history hash
    for (int k = 0; k < 40; k++)
      for (int j = 0; j < 4; j++) step(16'h0421, j != 3, 2'(k), "R3 R10");
    // R8: every random selector value
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 32; p++) step(16'(16'hA000 + p * 97), bit'((p ^ r) & 1), 2'(r), "R8");
    // R5 R7 R9 R11 R4: correlated traffic over a small PC pool
    lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] pc;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pc = {3'b000, lf[4:0], 3'b000, lf[9:5]} & 16'h1F1F;
      pc = pc % 16'd12 * 16'd1543;
      step(pc, pc[3] ^ m_gh[pc[1:0]] ^ (m_gh[4] & lf[11]), lf[15:14], "R5 R7 R9 R11 R4");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule